// File: doc/BRIEF.md
# Configurable-Polarity Host Port Front End

This block sits between the pins of a parallel host bus and the peripheral logic of a processor. The processor programs a small control word that sets the active level of the host chip select, the host acknowledge and the host request outputs. The same word enables the port and its requests, picks single-request or double-request signalling, and picks a multiplexed bus mode in which the chip-select level setting has no effect. Host strobes and select are brought through synchronizers and then decoded. A read strobe returns a data word supplied by the peripheral. A write strobe captures the host data into a one-cycle write pulse. An acknowledge returns the programmed interrupt vector byte.

The block also drives the host request pins from the peripheral's transmit-need and receive-need flags, and it owns the direction and output value of spare pins used as general-purpose I/O. Every pin-facing output comes from a register.

Top module: `host_pin_adapter`

## Requirements
- R1: After reset the control word is all zeros (active-low select, acknowledge and requests; port and requests disabled). Both request pins read 1, the data bus is not driven, and every GPIO pin is an input.
- R2: Processor writes use `cpu_addr`: 0 is the control word, 1 is the vector byte, 2 is GPIO direction, 3 is GPIO output data. Control word bits are: 0 port enable, 1 request enable, 2 double-request, 3 multiplexed mode, 4 select level, 5 request level, 6 acknowledge level.
- R3: Outside multiplexed mode the port is selected while `hcs` equals the select-level bit.
- R4: In multiplexed mode the port is selected while `hcs` is 0, whatever the select-level bit is.
- R5: Unless both port enable and request enable are 1, each request pin sits at its inactive level, which is the inverse of the request-level bit.
- R6: With requests enabled in single-request mode, `hreq_a` is asserted while `tx_need` or `rx_need` is 1 and `hreq_b` stays inactive. Asserted means equal to the request-level bit.
- R7: With requests enabled in double-request mode, `hreq_a` follows `tx_need` and `hreq_b` follows `rx_need`, both at the level the request-level bit sets.
- R8: While selected, an acknowledge (`hack` equal to the acknowledge-level bit) drives the vector byte onto `hdata_out` with `hdata_oe` high. An acknowledge wins over a read strobe in the same cycle.
- R9: While selected with no acknowledge, a low `hrd_n` drives `rd_data` onto the host bus.
- R10: The falling edge of `hwr_n` while selected loads `hdata_in` into `wr_data` and raises `wr_pulse` for exactly one cycle, at the third clock edge after the pin change. A strobe while not selected has no effect.
- R11: `hdata_oe` is 0 unless a selected read or acknowledge is in progress.
- R12: Each GPIO direction bit set to 1 makes that pin an output (`gpio_oe`), and `gpio_out` carries the GPIO data register. `gpio_in` shows on `gpio_rd` after two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Processor register write strobe |
| cpu_addr | input | 2 | Processor register select |
| cpu_wdata | input | DATA_W | Processor write data |
| rd_data | input | DATA_W | Word returned to the host on a read |
| tx_need | input | 1 | Peripheral wants the host to write |
| rx_need | input | 1 | Peripheral has data for the host |
| wr_data | output | DATA_W | Word captured on a host write |
| wr_pulse | output | 1 | One-cycle host write marker |
| gpio_rd | output | GPIO_W | Synchronized GPIO pin levels |
| hcs | input | 1 | Host chip select, level programmable |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| hack | input | 1 | Host acknowledge, level programmable |
| hdata_in | input | DATA_W | Host data bus input |
| hdata_out | output | DATA_W | Host data bus output |
| hdata_oe | output | 1 | Host data bus drive enable |
| hreq_a | output | 1 | Combined or transmit request pin |
| hreq_b | output | 1 | Receive request pin |
| gpio_in | input | GPIO_W | GPIO pin levels |
| gpio_out | output | GPIO_W | GPIO output values |
| gpio_oe | output | GPIO_W | GPIO drive enables |

## Verification
The acknowledge and the read strobe can both be active in the same cycle while the port is selected. Both would want the data bus, and only the vector byte may appear. The random stimulus leaves `hack` and `hrd_n` free, so the two collide often under every level setting. A directed case also holds both active with distinct vector and read words. In every such cycle the bench requires `hdata_oe` high and `hdata_out` equal to the vector byte.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  typedef struct packed {
    logic ack_pol;
    logic req_pol;
    logic cs_pol;
    logic mux_mode;
    logic dbl_req;
    logic req_en;
    logic port_en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_VEC  = 2'd1;
  localparam logic [1:0] A_DIR  = 2'd2;
  localparam logic [1:0] A_GDAT = 2'd3;
endpackage

// File: rtl/hpa_sync.sv
module hpa_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hpa_regs.sv
module hpa_regs
  import hpa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GPIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output ctl_t              ctl,
  output logic [DATA_W-1:0] vec,
  output logic [GPIO_W-1:0] dir,
  output logic [GPIO_W-1:0] gdat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      vec  <= '0;
      dir  <= '0;
      gdat <= '0;
    end else if (we) begin
      case (addr)
        A_CTL:   ctl  <= ctl_t'(wdata[CTL_W-1:0]);
        A_VEC:   vec  <= wdata;
        A_DIR:   dir  <= wdata[GPIO_W-1:0];
        default: gdat <= wdata[GPIO_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/hpa_bus.sv
module hpa_bus
  import hpa_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] vec,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              cs_s,
  input  logic              rd_n_s,
  input  logic              wr_n_s,
  input  logic              ack_s,
  input  logic [DATA_W-1:0] din_s,
  output logic              sel,
  output logic              ack_hit,
  output logic [DATA_W-1:0] hdata_out,
  output logic              hdata_oe,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_pulse
);
  logic cs_level;
  logic rd_hit;
  logic wr_hit;
  logic wr_prev;

  // multiplexed mode pins the select level to low
  assign cs_level = ctl.mux_mode ? 1'b0 : ctl.cs_pol;
  assign sel      = (cs_s == cs_level);
  assign ack_hit  = sel && (ack_s == ctl.ack_pol);
  assign rd_hit   = sel && !rd_n_s;
  assign wr_hit   = sel && !wr_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdata_out <= '0;
      hdata_oe  <= 1'b0;
      wr_data   <= '0;
      wr_pulse  <= 1'b0;
      wr_prev   <= 1'b0;
    end else begin
      hdata_oe <= ack_hit || rd_hit;
      if (ack_hit)     hdata_out <= vec;
      else if (rd_hit) hdata_out <= rd_data;
      wr_prev  <= wr_hit;
      wr_pulse <= wr_hit && !wr_prev;
      if (wr_hit && !wr_prev) wr_data <= din_s;
    end
  end
endmodule

// File: rtl/hpa_req.sv
module hpa_req
  import hpa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctl_t ctl,
  input  logic tx_need,
  input  logic rx_need,
  output logic hreq_a,
  output logic hreq_b
);
  logic on;
  logic want_a;
  logic want_b;

  assign on     = ctl.port_en && ctl.req_en;
  assign want_a = on && (ctl.dbl_req ? tx_need : (tx_need || rx_need));
  assign want_b = on && ctl.dbl_req && rx_need;

  // level mapping is registered, so a level change moves the pin once
  always_ff @(posedge clk) begin
    if (rst) begin
      hreq_a <= 1'b1;
      hreq_b <= 1'b1;
    end else begin
      hreq_a <= ctl.req_pol ? want_a : !want_a;
      hreq_b <= ctl.req_pol ? want_b : !want_b;
    end
  end
endmodule

// File: rtl/host_pin_adapter.sv
module host_pin_adapter
  import hpa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GPIO_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              tx_need,
  input  logic              rx_need,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_pulse,
  output logic [GPIO_W-1:0] gpio_rd,
  input  logic              hcs,
  input  logic              hrd_n,
  input  logic              hwr_n,
  input  logic              hack,
  input  logic [DATA_W-1:0] hdata_in,
  output logic [DATA_W-1:0] hdata_out,
  output logic              hdata_oe,
  output logic              hreq_a,
  output logic              hreq_b,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] gpio_out,
  output logic [GPIO_W-1:0] gpio_oe
);
  localparam int CTRL_PINS = 4;

  ctl_t              ctl_q;
  logic [DATA_W-1:0] vec_q;
  logic [GPIO_W-1:0] dir_q;
  logic [GPIO_W-1:0] gdat_q;
  logic [CTRL_PINS-1:0] pins_s;
  logic [DATA_W-1:0] din_s;
  logic bus_sel;
  logic ack_hit;
  logic c_pen, c_ren, c_dbl, c_rpol;

  assign c_pen  = ctl_q.port_en;
  assign c_ren  = ctl_q.req_en;
  assign c_dbl  = ctl_q.dbl_req;
  assign c_rpol = ctl_q.req_pol;

  hpa_regs #(.DATA_W(DATA_W), .GPIO_W(GPIO_W)) u_regs (
    .clk(clk), .rst(rst), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata),
    .ctl(ctl_q), .vec(vec_q), .dir(dir_q), .gdat(gdat_q)
  );

  hpa_sync #(.W(CTRL_PINS), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_PINS{1'b1}})) u_sync_ctl (
    .clk(clk), .rst(rst), .d({hcs, hrd_n, hwr_n, hack}), .q(pins_s)
  );

  hpa_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst(rst), .d(hdata_in), .q(din_s)
  );

  hpa_sync #(.W(GPIO_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_gpio (
    .clk(clk), .rst(rst), .d(gpio_in), .q(gpio_rd)
  );

  hpa_bus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .ctl(ctl_q), .vec(vec_q), .rd_data(rd_data),
    .cs_s(pins_s[3]), .rd_n_s(pins_s[2]), .wr_n_s(pins_s[1]), .ack_s(pins_s[0]),
    .din_s(din_s), .sel(bus_sel), .ack_hit(ack_hit),
    .hdata_out(hdata_out), .hdata_oe(hdata_oe), .wr_data(wr_data), .wr_pulse(wr_pulse)
  );

  hpa_req u_req (
    .clk(clk), .rst(rst), .ctl(ctl_q), .tx_need(tx_need), .rx_need(rx_need),
    .hreq_a(hreq_a), .hreq_b(hreq_b)
  );

  assign gpio_oe  = dir_q;
  assign gpio_out = gdat_q;
endmodule

// File: rtl/hpa_checker.sv
module hpa_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              port_en,
  input logic              req_en,
  input logic              dbl_req,
  input logic              req_pol,
  input logic              hreq_a,
  input logic              hreq_b,
  input logic              bus_sel,
  input logic              ack_hit,
  input logic [DATA_W-1:0] vec,
  input logic [DATA_W-1:0] hdata_out,
  input logic              hdata_oe,
  input logic              wr_pulse
);
  AST_REQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !(port_en && req_en) |=> (hreq_a == !$past(req_pol) && hreq_b == !$past(req_pol))); // R5

  AST_SINGLE_B_IDLE: assert property (@(posedge clk) disable iff (rst)
    !dbl_req |=> (hreq_b == !$past(req_pol))); // R6

  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> (hdata_oe && hdata_out == $past(vec))); // R8

  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    hdata_oe |-> $past(bus_sel)); // R11

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse); // R10
endmodule

bind host_pin_adapter hpa_checker #(.DATA_W(DATA_W)) u_hpa_chk (
  .clk(clk), .rst(rst), .port_en(c_pen), .req_en(c_ren), .dbl_req(c_dbl),
  .req_pol(c_rpol), .hreq_a(hreq_a), .hreq_b(hreq_b), .bus_sel(bus_sel),
  .ack_hit(ack_hit), .vec(vec_q), .hdata_out(hdata_out), .hdata_oe(hdata_oe),
  .wr_pulse(wr_pulse)
);

// File: tb/host_pin_adapter_bench.sv
`timescale 1ns/1ps
module host_pin_adapter_bench;
  localparam int DATA_W = 8;
  localparam int GPIO_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] rd_data = '0;
  logic tx_need = 1'b0, rx_need = 1'b0;
  logic [DATA_W-1:0] wr_data;
  logic wr_pulse;
  logic [GPIO_W-1:0] gpio_rd;
  logic hcs = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1, hack = 1'b1;
  logic [DATA_W-1:0] hdata_in = '0;
  logic [DATA_W-1:0] hdata_out;
  logic hdata_oe, hreq_a, hreq_b;
  logic [GPIO_W-1:0] gpio_in = '0;
  logic [GPIO_W-1:0] gpio_out, gpio_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  host_pin_adapter #(.DATA_W(DATA_W), .GPIO_W(GPIO_W)) u_host_pin_adapter (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rd_data(rd_data), .tx_need(tx_need), .rx_need(rx_need), .wr_data(wr_data),
    .wr_pulse(wr_pulse), .gpio_rd(gpio_rd), .hcs(hcs), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .hack(hack), .hdata_in(hdata_in), .hdata_out(hdata_out), .hdata_oe(hdata_oe),
    .hreq_a(hreq_a), .hreq_b(hreq_b), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  function automatic logic exp_sel(input logic [6:0] c, input logic cs);
    return c[3] ? (cs == 1'b0) : (cs == c[4]);
  endfunction

  function automatic logic exp_pin(input logic pol, input logic want);
    return pol ? want : !want;
  endfunction

  function automatic logic want_a(input logic [6:0] c, input logic tx, input logic rx);
    return c[0] && c[1] && (c[2] ? tx : (tx || rx));
  endfunction

  function automatic logic want_b(input logic [6:0] c, input logic rx);
    return c[0] && c[1] && c[2] && rx;
  endfunction

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] c;
    logic [DATA_W-1:0] v;
    logic [GPIO_W-1:0] dr, gd;
    logic s, ak, rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 hreq_a", hreq_a, 1);
    chk("R1 hreq_b", hreq_b, 1);
    chk("R1 hdata_oe", hdata_oe, 0);
    chk("R1 gpio_oe", gpio_oe, 0);
    chk("R1 wr_pulse", wr_pulse, 0);

    // R8 acknowledge and read together: vector wins
    cpu_wr(2'd0, 8'h01);
    cpu_wr(2'd1, 8'hA5);
    @(negedge clk);
    rd_data = 8'h3C; hcs = 1'b0; hack = 1'b0; hrd_n = 1'b0;
    settle();
    chk("R8 collide oe", hdata_oe, 1);
    chk("R8 collide data", hdata_out, 8'hA5);
    @(negedge clk) hack = 1'b1;
    settle();
    chk("R9 read data", hdata_out, 8'h3C);
    @(negedge clk) hrd_n = 1'b1;
    settle();
    chk("R11 idle tristate", hdata_oe, 0);

    // R4 multiplexed mode: select-level bit ignored, select low
    cpu_wr(2'd0, 8'h19);
    @(negedge clk) hcs = 1'b0; hrd_n = 1'b0;
    settle();
    chk("R4 mux low selects", hdata_oe, 1);
    @(negedge clk) hcs = 1'b1;
    settle();
    chk("R4 mux high deselects", hdata_oe, 0);
    @(negedge clk) hrd_n = 1'b1;

    // R10 write capture timing, then unselected write ignored
    cpu_wr(2'd0, 8'h11);
    @(negedge clk) hcs = 1'b1; hdata_in = 8'h5A;
    settle();
    @(negedge clk) hwr_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R10 no pulse early", wr_pulse, 0);
    @(posedge clk); #1;
    chk("R10 pulse", wr_pulse, 1);
    chk("R10 data", wr_data, 8'h5A);
    @(posedge clk); #1;
    chk("R10 single cycle", wr_pulse, 0);
    @(negedge clk) hwr_n = 1'b1; hcs = 1'b0; hdata_in = 8'hC3;
    settle();
    @(negedge clk) hwr_n = 1'b0;
    repeat (3) @(posedge clk); #1;
    chk("R10 unselected pulse", wr_pulse, 0);
    chk("R10 unselected data", wr_data, 8'h5A);
    @(negedge clk) hwr_n = 1'b1;

    // random mix
    void'($urandom(32'h1234));
    for (int i = 0; i < 400; i++) begin
      c  = 7'($urandom);
      v  = 8'($urandom);
      dr = 4'($urandom);
      gd = 4'($urandom);
      cpu_wr(2'd0, {1'b0, c});
      cpu_wr(2'd1, v);
      cpu_wr(2'd2, {4'h0, dr});
      cpu_wr(2'd3, {4'h0, gd});
      @(negedge clk);
      hcs = 1'($urandom); hrd_n = 1'($urandom); hack = 1'($urandom);
      tx_need = 1'($urandom); rx_need = 1'($urandom);
      rd_data = 8'($urandom); gpio_in = 4'($urandom);
      settle();
      s  = exp_sel(c, hcs);
      ak = s && (hack == c[6]);
      rd = s && !hrd_n;
      if (!(c[0] && c[1])) begin
        chk("R5 a off", hreq_a, !c[5]);
        chk("R5 b off", hreq_b, !c[5]);
      end else if (!c[2]) begin
        chk("R6 a", hreq_a, exp_pin(c[5], want_a(c, tx_need, rx_need)));
        chk("R6 b", hreq_b, exp_pin(c[5], want_b(c, rx_need)));
      end else begin
        chk("R7 a", hreq_a, exp_pin(c[5], want_a(c, tx_need, rx_need)));
        chk("R7 b", hreq_b, exp_pin(c[5], want_b(c, rx_need)));
      end
      if (c[3]) chk("R4 oe", hdata_oe, ak || rd);
      else      chk("R3 oe", hdata_oe, ak || rd);
      chk("R11 oe", hdata_oe, ak || rd);
      if (ak)      chk("R8 vector", hdata_out, v);
      else if (rd) chk("R9 read", hdata_out, rd_data);
      chk("R12 dir", gpio_oe, dr);
      chk("R12 out", gpio_out, gd);
      chk("R12 in", gpio_rd, gpio_in);
      chk("R2 map", {gpio_oe, gpio_out}, {dr, gd});
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule